// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus when a slave has stopped partway through a byte and is holding SDA low. A controller starts it after SDA has stayed low beyond the wait that comes before a new transfer. It then takes over both bus lines through an override path that bypasses the normal protocol engine. With SDA left released, it clocks SCL nine times, so the stuck slave can shift out whatever remains of its byte and let go of SDA. It then drives a STOP condition and finally samples SDA to decide whether the bus is usable again.

Each bus phase lasts for a half-period given as a count of system-clock cycles. That count is captured when the sequence starts. A count of 5 us gives a bus clock near 100 kHz. The pin outputs follow open-drain convention: a pull output at 1 drives the line low, and at 0 it releases the line. When the sequence ends, a one-cycle done pulse is raised and the override is dropped in the same cycle. A busy flag keeps the outcome until the next accepted start.

Top module: `busclr_seq`

## Requirements
- R1: After reset the block is idle: `ovr_o`, `scl_pull_o`, `sda_pull_o`, `done_o` and `busy_o` are all 0. Whenever `ovr_o` is 0, neither pull output is 1.
- R2: A start sampled while idle makes `ovr_o` 1 from the next cycle until the sequence ends. SDA stays released (`sda_pull_o`=0) for the whole clocking phase.
- R3: The clocking phase is exactly 9 SCL pulses. Each pulse is SCL released (`scl_pull_o`=0) for one half-period followed by SCL pulled low for one half-period.
- R4: One half-period is H cycles, where H is `half_i` captured at the accepted start. A value of 0 is treated as 1. Changing `half_i` during a sequence has no effect on it.
- R5: Right after the pulses comes a STOP phase of five half-periods, given as (SCL, SDA) levels where 1 means released: (0,1), (0,1), (0,0), (1,0), (1,1).
- R6: In the cycle after the last STOP half-period, `done_o` is 1 for exactly one cycle, `ovr_o` is 0, and `busy_o` equals the inverse of `sda_in_i` as sampled at the end of that last half-period.
- R7: `busy_o` keeps its value while a sequence runs and after it ends. It is cleared only by an accepted start.
- R8: A start asserted while a sequence is running is ignored. The pin waveform and the moment of completion do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin a recovery sequence |
| half_i | input | HW (16) | Half-period length in clock cycles |
| sda_in_i | input | 1 | Synchronised SDA line level |
| ovr_o | output | 1 | Pin override active |
| scl_pull_o | output | 1 | 1 drives SCL low, 0 releases it |
| sda_pull_o | output | 1 | 1 drives SDA low, 0 releases it |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Bus still held low after recovery |

## Verification
A wrong phase state or pulse count shows at the pull outputs within one half-period: an extra or missing SCL pulse, SDA pulled during clocking, or a misplaced STOP edge. The bench compares every cycle of every run against a model computed from H, so any such error is caught on the first cycle it occurs. A half-period timer that reloads incorrectly shifts the next edge by at least one cycle and is caught at that edge. A bad result register shows up as a wrong `busy_o` or a missing or stretched `done_o` on the cycle right after completion.

// File: rtl/busclr_pkg.sv
// Package: shared phase type and the STOP level pattern of the bus-clear sequencer.
package busclr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CLK_HI = 2'd1,
        PH_CLK_LO = 2'd2,
        PH_STOP   = 2'd3
    } busclr_phase_e;

    localparam int STOP_STEPS = 5;

    // Bus levels {scl, sda} (1 = released) for each STOP half-period.
    function automatic logic [1:0] stop_levels(input logic [2:0] step);
        case (step)
            3'd0, 3'd1: stop_levels = 2'b01;
            3'd2:       stop_levels = 2'b00;
            3'd3:       stop_levels = 2'b10;
            default:    stop_levels = 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/busclr_timer.sv
// Half-period timer. Captures the half-period length on load (0 becomes 1),
// then raises tick on the last cycle of every half-period while run is high.
// Assumes load and run are never high together.
module busclr_timer #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          run_i,
    input  logic [HW-1:0] half_i,
    output logic          tick_o
);
    logic [HW-1:0] len_q;
    logic [HW-1:0] cnt_q;
    logic [HW-1:0] len_eff;

    // Clamp a zero length to one cycle.
    always_comb len_eff = (half_i == '0) ? HW'(1) : half_i;

    // Capture the length and count down the current half-period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= HW'(1);
            cnt_q <= '0;
        end else if (load_i) begin
            len_q <= len_eff;
            cnt_q <= len_eff - HW'(1);
        end else if (run_i) begin
            if (cnt_q == '0) cnt_q <= len_q - HW'(1);
            else             cnt_q <= cnt_q - HW'(1);
        end
    end

    // A half-period ends when the count reaches zero.
    always_comb tick_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/busclr_fsm.sv
// Phase sequencer. Steps through PULSES SCL pulses with SDA released, then
// the five STOP half-periods, advancing on each timer tick. Outputs the
// requested line levels (1 = released) and a finish strobe on the last tick.
module busclr_fsm
    import busclr_pkg::*;
#(
    parameter int PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic tick_i,
    output logic idle_o,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic finish_o
);
    localparam int PCW = (PULSES > 1) ? $clog2(PULSES) : 1;
    localparam logic [PCW-1:0] LAST_PULSE = PCW'(PULSES - 1);
    localparam logic [2:0]     LAST_STEP  = 3'(STOP_STEPS - 1);

    busclr_phase_e  ph_q;
    logic [PCW-1:0] pcnt_q;
    logic [2:0]     step_q;

    // Phase, pulse and STOP-step progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            pcnt_q <= '0;
            step_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (accept_i) begin
                    ph_q   <= PH_CLK_HI;
                    pcnt_q <= '0;
                    step_q <= '0;
                end
                PH_CLK_HI: if (tick_i) ph_q <= PH_CLK_LO;
                PH_CLK_LO: if (tick_i) begin
                    if (pcnt_q == LAST_PULSE) begin
                        ph_q <= PH_STOP;
                    end else begin
                        ph_q   <= PH_CLK_HI;
                        pcnt_q <= pcnt_q + PCW'(1);
                    end
                end
                default: if (tick_i) begin
                    if (step_q == LAST_STEP) ph_q <= PH_IDLE;
                    else                     step_q <= step_q + 3'd1;
                end
            endcase
        end
    end

    // Line levels requested by the current phase.
    always_comb begin
        case (ph_q)
            PH_CLK_LO: {scl_lvl_o, sda_lvl_o} = 2'b01;
            PH_STOP:   {scl_lvl_o, sda_lvl_o} = stop_levels(step_q);
            default:   {scl_lvl_o, sda_lvl_o} = 2'b11;
        endcase
    end

    // Status toward the top level.
    always_comb begin
        idle_o   = (ph_q == PH_IDLE);
        finish_o = (ph_q == PH_STOP) && tick_i && (step_q == LAST_STEP);
    end

endmodule

// File: rtl/busclr_result.sv
// Result holder. Clears on an accepted start, and on finish records busy as
// the inverse of the sampled SDA and raises done for one cycle.
module busclr_result (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic finish_i,
    input  logic sda_in_i,
    output logic done_o,
    output logic busy_o
);
    // Done pulse and held pass/fail flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            busy_o <= 1'b0;
        end else begin
            done_o <= finish_i;
            if (accept_i)      busy_o <= 1'b0;
            else if (finish_i) busy_o <= ~sda_in_i;
        end
    end

endmodule

// File: rtl/busclr_seq.sv
// Bus-clear recovery sequencer top. Overrides SCL/SDA to give nine clock
// pulses, a STOP, and an SDA check. Assumes sda_in_i is already synchronised.
module busclr_seq #(
    parameter int HW     = 16,
    parameter int PULSES = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [HW-1:0] half_i,
    input  logic          sda_in_i,
    output logic          ovr_o,
    output logic          scl_pull_o,
    output logic          sda_pull_o,
    output logic          done_o,
    output logic          busy_o
);
    logic idle, tick, finish, accept, scl_lvl, sda_lvl;

    // A start counts only while idle.
    always_comb accept = start_i && idle;

    busclr_timer #(.HW(HW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .run_i  (!idle),
        .half_i (half_i),
        .tick_o (tick)
    );

    busclr_fsm #(.PULSES(PULSES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .tick_i    (tick),
        .idle_o    (idle),
        .scl_lvl_o (scl_lvl),
        .sda_lvl_o (sda_lvl),
        .finish_o  (finish)
    );

    busclr_result u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .finish_i (finish),
        .sda_in_i (sda_in_i),
        .done_o   (done_o),
        .busy_o   (busy_o)
    );

    // Open-drain pin drive: pull low only under override.
    always_comb begin
        ovr_o      = !idle;
        scl_pull_o = !idle && !scl_lvl;
        sda_pull_o = !idle && !sda_lvl;
    end

endmodule

// File: rtl/busclr_chk.sv
// Checker for busclr_seq: port-level temporal properties, attached by bind.
module busclr_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic ovr_o,
    input logic scl_pull_o,
    input logic sda_pull_o,
    input logic done_o,
    input logic busy_o
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_o |-> (!scl_pull_o && !sda_pull_o)); // R1
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !ovr_o) |=> ovr_o); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!ovr_o && $past(ovr_o))); // R6
    AST_BUSY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> done_o); // R6
    AST_BUSY_HOLD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o && $past(ovr_o)) |-> $stable(busy_o)); // R7
endmodule

bind busclr_seq busclr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .ovr_o      (ovr_o),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o),
    .done_o     (done_o),
    .busy_o     (busy_o)
);

// File: tb/sim_busclr_seq.sv
module sim_busclr_seq;
    localparam int HW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [HW-1:0] half_i = '0;
    logic          stuck = 1'b0;
    logic          sda_in_i;
    logic          ovr_o, scl_pull_o, sda_pull_o, done_o, busy_o;
    int            n_run = 0;
    int            n_fail = 0;
    int            cyc = 0;
    bit            finished = 1'b0;

    always #2.5 clk = ~clk;

    // Bus model: SDA low if the block pulls it or the slave is stuck.
    assign sda_in_i = !sda_pull_o && !stuck;

    busclr_seq #(.HW(HW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_i(half_i),
        .sda_in_i(sda_in_i), .ovr_o(ovr_o), .scl_pull_o(scl_pull_o),
        .sda_pull_o(sda_pull_o), .done_o(done_o), .busy_o(busy_o)
    );

    // Expected {scl, sda} level (1 = released) at cycle idx of a run.
    function automatic logic [1:0] exp_lvl(input int idx, input int h);
        int seg = idx / h;
        if (seg < 18) return (seg % 2 == 0) ? 2'b11 : 2'b01;
        case (seg - 18)
            0, 1:    return 2'b01;
            2:       return 2'b00;
            3:       return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%b exp=%b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // One full recovery; hval is the captured half_i, mid_start pulses start mid-run.
    task automatic run_seq(input int hval, input bit stk, input int mid_start);
        int h = (hval == 0) ? 1 : hval;
        int total = 23 * h;
        stuck = stk;
        @(negedge clk);
        half_i = HW'(hval);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        half_i = HW'($urandom_range(1, 9)); // R4: ignored after capture
        for (int i = 0; i < total; i++) begin
            logic [1:0] l = exp_lvl(i, h);
            if (i < 18 * h)
                check(i == 0 ? "R2" : "R3", {ovr_o, scl_pull_o, sda_pull_o, done_o},
                      {1'b1, ~l[1], ~l[0], 1'b0});
            else
                check("R5", {ovr_o, scl_pull_o, sda_pull_o, done_o},
                      {1'b1, ~l[1], ~l[0], 1'b0});
            if (i == 0) check("R7", {3'b0, busy_o}, 4'b0);
            start_i = (i == mid_start); // R8: ignored while running
            @(negedge clk);
        end
        start_i = 1'b0;
        check("R6", {ovr_o, scl_pull_o, sda_pull_o, done_o}, 4'b0001);
        check("R6", {3'b0, busy_o}, {3'b0, stk});
        @(negedge clk);
        check("R6", {3'b0, done_o}, 4'b0);
        stuck = 1'b0;
        repeat (3) @(negedge clk);
        check("R7", {ovr_o, 2'b0, busy_o}, {1'b0, 2'b0, stk});
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            n_fail++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", {ovr_o, scl_pull_o, sda_pull_o, done_o}, 4'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {ovr_o, scl_pull_o, sda_pull_o, busy_o}, 4'b0);
        // Directed corners.
        run_seq(1, 1'b0, -1);
        run_seq(0, 1'b1, -1);   // R4: zero treated as one
        run_seq(3, 1'b1, 10);   // R8
        run_seq(2, 1'b0, 40);   // R8, clears busy (R7)
        // Random runs.
        for (int k = 0; k < 20; k++) begin
            int h = $urandom_range(1, 6);
            run_seq(h, bit'($urandom_range(0, 1)),
                    ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 23 * h - 1)) : -1);
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule